// File: doc/BRIEF.md
# SD Host Command and Status Unit

This block is the command side of an SD host controller. Software writes a command word and a 32-bit argument through a small register port. A set launch bit in the command word starts a request on a simplified card-side handshake. That handshake answers with a byte count and up to sixteen response bytes. The unit checks the count against the response type the command asked for. It stores a valid response as 32-bit words, and on a bad or missing response it sets a sticky failure flag together with a timeout status bit.

Interrupt status bits are cleared by writing ones to them, and a single interrupt line follows the interrupt-class status bits. Line serialisation, CRC and clock division are handled elsewhere. The timeout and divider registers accept writes but hold nothing.

Register map (byte offsets): command 0x00, argument 0x04, timeout 0x08, divider 0x0C, response words 0x10/0x14/0x18/0x1C (word 0 first), status 0x20, configuration 0x24.

Top module: `sd_cmd_ctrl`

## Requirements
- R1: Writing the command register with bit 15 set, while no command is outstanding, raises card_req in the next cycle with card_idx equal to command bits 5:0. Bit 15 then reads 1 until the card's ack is taken, and reads 0 from the cycle after the ack.
- R2: A response of 4 bytes is stored big-endian in response word 0 (byte 0 is the most significant byte), and words 1 to 3 are zeroed. Byte i of the card response is card_rsp[8i+7:8i].
- R3: A 16-byte response is stored with its word order reversed. Bytes 12..15 go to word 0, 8..11 to word 1, 4..7 to word 2 and 0..3 to word 3, and each word is big-endian.
- R4: When a response is expected (command bit 10 clear), the command fails if the length is 0, if it is 4 on a long command (bit 9 set), or if it is neither 4 nor 16. On failure, command bit 14 and status bit 6 are set and the response words are left unchanged.
- R5: A command with bit 10 set accepts any length, never fails and leaves the response words unchanged.
- R6: A busy-wait command (bit 11) that completes without failing sets status bit 10 only when configuration bit 10 is set.
- R7: A write to the status register clears each bit written as 1 and keeps the others.
- R8: irq_o is high exactly when any of status bits 10, 9 or 8 is set.
- R9: After reset, command, argument, configuration, status and response registers read 0, and irq_o is low.
- R10: Writes to the timeout and divider registers, and to unmapped offsets, change nothing. Reads of those offsets return 0.
- R11: While a command is outstanding, writes to the command and argument registers are ignored, and card_idx and card_arg stay stable.
- R12: The failure flag (command bit 14) stays set after completion until software next writes the command register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| card_req | output | 1 | Command request, held until card_ack |
| card_idx | output | 6 | Command index to the card |
| card_arg | output | 32 | Command argument to the card |
| card_ack | input | 1 | One-cycle response strobe |
| card_len | input | LEN_W | Response length in bytes |
| card_rsp | input | 32*RSP_WORDS | Response bytes, byte i at bits 8i+7:8i |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that card_ack only arrives while card_req is high and lasts one cycle per request. They also assume that software clears status bits only through the status register. The stimulus drives the card model only after it has seen card_req, and it drops the ack after a single cycle. Writes that land during an outstanding command are made on purpose, to exercise the ignore rule. All inputs change on the falling edge, so the register port and the handshake never move at the sampling edge.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   localparam int CMD_W  = 16;
   localparam int WORD_W = 32;
   localparam int IDX_W  = 6;

   localparam logic [7:0] OFS_CMD = 8'h00;
   localparam logic [7:0] OFS_ARG = 8'h04;
   localparam logic [7:0] OFS_TMO = 8'h08;
   localparam logic [7:0] OFS_DIV = 8'h0C;
   localparam logic [7:0] OFS_RSP = 8'h10;
   localparam logic [7:0] OFS_STS = 8'h20;
   localparam logic [7:0] OFS_CFG = 8'h24;

   localparam int CB_GO    = 15;
   localparam int CB_FAIL  = 14;
   localparam int CB_BUSYW = 11;
   localparam int CB_NORSP = 10;
   localparam int CB_LONG  = 9;

   localparam int SB_TMO    = 6;
   localparam int SB_BUSY   = 10;
   localparam int SB_IRQ_LO = 8;
   localparam int SB_IRQ_HI = 10;

   localparam int CF_BUSYEN = 10;

   typedef enum logic {LS_IDLE, LS_WAIT} launch_st_t;
endpackage

// File: rtl/sdc_launch.sv
module sdc_launch
   import sdc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic card_ack,
   output logic card_req,
   output logic busy,
   output logic done
);
   launch_st_t st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= LS_IDLE;
      end else begin
         case (st_q)
            LS_IDLE: if (go) st_q <= LS_WAIT;
            LS_WAIT: if (card_ack) st_q <= LS_IDLE;
            default: st_q <= LS_IDLE;
         endcase
      end
   end

   assign busy     = (st_q == LS_WAIT);
   assign card_req = busy;
   assign done     = busy && card_ack;

   // R1
   launch_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go && !busy |=> card_req);
   // R1
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_req && !card_ack |=> card_req);
   // R1
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_req && card_ack |=> !card_req);
endmodule

// File: rtl/sdc_resp_eval.sv
module sdc_resp_eval
   import sdc_pkg::*;
#(
   parameter int RSP_WORDS = 4,
   parameter int LEN_W     = 5
) (
   input  logic                              want,
   input  logic                              long_cmd,
   input  logic [LEN_W-1:0]                  len,
   input  logic [RSP_WORDS*WORD_W-1:0]       bytes_i,
   output logic                              fail,
   output logic [RSP_WORDS-1:0][WORD_W-1:0]  words
);
   localparam int SHORT_LEN = 4;
   localparam int LONG_LEN  = 4 * RSP_WORDS;

   logic is_short, is_long;
   assign is_short = (len == LEN_W'(SHORT_LEN));
   assign is_long  = (len == LEN_W'(LONG_LEN));
   assign fail     = want && ((is_short && long_cmd) || (!is_short && !is_long));

   for (genvar k = 0; k < RSP_WORDS; k++) begin : g_word
      localparam int G = RSP_WORDS - 1 - k;
      logic [WORD_W-1:0] long_w, short_w;
      assign long_w = {bytes_i[8*(4*G)+:8],   bytes_i[8*(4*G+1)+:8],
                       bytes_i[8*(4*G+2)+:8], bytes_i[8*(4*G+3)+:8]};
      if (k == 0) begin : g_low
         assign short_w = {bytes_i[0+:8], bytes_i[8+:8], bytes_i[16+:8], bytes_i[24+:8]};
      end else begin : g_high
         assign short_w = '0;
      end
      assign words[k] = is_short ? short_w : long_w;
   end
endmodule

// File: rtl/sdc_status.sv
module sdc_status
   import sdc_pkg::*;
#(
   parameter int STS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [STS_W-1:0] clr_mask,
   input  logic [STS_W-1:0] set_mask,
   output logic [STS_W-1:0] sts,
   output logic             irq_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) sts <= '0;
      else        sts <= (sts & ~clr_mask) | set_mask;
   end

   assign irq_o = |sts[SB_IRQ_HI:SB_IRQ_LO];

   // R7
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts & $past(clr_mask & ~set_mask)) == '0));
   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(|set_mask[SB_IRQ_HI:SB_IRQ_LO]));
endmodule

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
   import sdc_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int RSP_WORDS = 4,
   parameter int LEN_W     = 5,
   parameter int STS_W     = 11,
   parameter int CFG_W     = 11
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_we,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [WORD_W-1:0]           bus_wdata,
   output logic [WORD_W-1:0]           bus_rdata,
   output logic                        card_req,
   output logic [IDX_W-1:0]            card_idx,
   output logic [WORD_W-1:0]           card_arg,
   input  logic                        card_ack,
   input  logic [LEN_W-1:0]            card_len,
   input  logic [RSP_WORDS*WORD_W-1:0] card_rsp,
   output logic                        irq_o
);
   localparam int RSP_BYTES = 4 * RSP_WORDS;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end
   if (RSP_WORDS < 2 || RSP_WORDS > 4) begin : g_bad_words
      $error("RSP_WORDS must lie in 2..4");
   end
   if (RSP_BYTES >= (1 << LEN_W)) begin : g_bad_len
      $error("LEN_W cannot encode a long response length");
   end
   if (STS_W <= SB_IRQ_HI || CFG_W <= CF_BUSYEN) begin : g_bad_sts
      $error("status and configuration must hold bit 10");
   end

   logic [CMD_W-1:0]                 cmd_q;
   logic [WORD_W-1:0]                arg_q;
   logic [CFG_W-1:0]                 cfg_q;
   logic [RSP_WORDS-1:0][WORD_W-1:0] rsp_q;
   logic [RSP_WORDS-1:0][WORD_W-1:0] rsp_new;
   logic [STS_W-1:0]                 sts, clr_mask, set_mask;
   logic                             busy, done, fail, go;
   logic                             wr_cmd, wr_arg, wr_cfg, wr_sts;

   assign wr_cmd = bus_we && (bus_addr == ADDR_W'(OFS_CMD));
   assign wr_arg = bus_we && (bus_addr == ADDR_W'(OFS_ARG));
   assign wr_cfg = bus_we && (bus_addr == ADDR_W'(OFS_CFG));
   assign wr_sts = bus_we && (bus_addr == ADDR_W'(OFS_STS));
   assign go     = wr_cmd && bus_wdata[CB_GO] && !busy;

   sdc_launch u_launch (
      .clk(clk), .rst_n(rst_n), .go(go), .card_ack(card_ack),
      .card_req(card_req), .busy(busy), .done(done)
   );

   sdc_resp_eval #(.RSP_WORDS(RSP_WORDS), .LEN_W(LEN_W)) u_eval (
      .want(!cmd_q[CB_NORSP]), .long_cmd(cmd_q[CB_LONG]), .len(card_len),
      .bytes_i(card_rsp), .fail(fail), .words(rsp_new)
   );

   always_comb begin
      set_mask = '0;
      if (done && fail) set_mask[SB_TMO] = 1'b1;
      if (done && !fail && cmd_q[CB_BUSYW] && cfg_q[CF_BUSYEN]) set_mask[SB_BUSY] = 1'b1;
   end
   assign clr_mask = wr_sts ? bus_wdata[STS_W-1:0] : '0;

   sdc_status #(.STS_W(STS_W)) u_status (
      .clk(clk), .rst_n(rst_n), .clr_mask(clr_mask), .set_mask(set_mask),
      .sts(sts), .irq_o(irq_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
         arg_q <= '0;
         cfg_q <= '0;
         rsp_q <= '0;
      end else begin
         if (wr_cmd && !busy) begin
            cmd_q <= bus_wdata[CMD_W-1:0];
         end else if (done) begin
            cmd_q[CB_GO] <= 1'b0;
            if (fail) cmd_q[CB_FAIL] <= 1'b1;
         end
         if (wr_arg && !busy) arg_q <= bus_wdata;
         if (wr_cfg) cfg_q <= bus_wdata[CFG_W-1:0];
         if (done && !fail && !cmd_q[CB_NORSP]) rsp_q <= rsp_new;
      end
   end

   assign card_idx = cmd_q[IDX_W-1:0];
   assign card_arg = arg_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CMD)) bus_rdata = WORD_W'(cmd_q);
      if (bus_addr == ADDR_W'(OFS_ARG)) bus_rdata = arg_q;
      if (bus_addr == ADDR_W'(OFS_CFG)) bus_rdata = WORD_W'(cfg_q);
      if (bus_addr == ADDR_W'(OFS_STS)) bus_rdata = WORD_W'(sts);
      for (int k = 0; k < RSP_WORDS; k++) begin
         if (bus_addr == ADDR_W'(int'(OFS_RSP) + 4 * k)) bus_rdata = rsp_q[k];
      end
   end

   // R1
   go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !cmd_q[CB_GO]);
   // R4
   fail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && fail |=> cmd_q[CB_FAIL] && sts[SB_TMO]);
   // R5
   norsp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && cmd_q[CB_NORSP] |=> rsp_q == $past(rsp_q));
   // R11
   req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_req && !card_ack |=> $stable(card_idx) && $stable(card_arg));
endmodule

// File: tb/sd_cmd_ctrl_test.sv
module sd_cmd_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_we = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic         card_req;
   logic [5:0]   card_idx;
   logic [31:0]  card_arg;
   logic         card_ack = 1'b0;
   logic [4:0]   card_len = '0;
   logic [127:0] card_rsp = '0;
   logic         irq_o;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sd_cmd_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_req(card_req),
      .card_idx(card_idx), .card_arg(card_arg), .card_ack(card_ack),
      .card_len(card_len), .card_rsp(card_rsp), .irq_o(irq_o)
   );

   // monitor: kind 0 read data, 1 irq, 2 {req,idx}, 3 argument
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
               0: act = bus_rdata;
               1: act = {31'b0, irq_o};
               2: act = {25'b0, card_req, card_idx};
               default: act = card_arg;
            endcase
            n_run++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic expect_item(input int kind, input logic [7:0] a,
                              input logic [31:0] e, input string tag);
      item_t it;
      if (kind == 0) bus_addr = a;
      it.kind = kind; it.exp = e; it.tag = tag;
      q.push_back(it);
      @(negedge clk);
   endtask

   task automatic reply(input int len, input logic [127:0] data);
      card_ack = 1'b1; card_len = 5'(len); card_rsp = data;
      @(negedge clk);
      card_ack = 1'b0; card_len = '0;
   endtask

   function automatic logic [127:0] ramp(input logic [7:0] base);
      logic [127:0] r;
      for (int i = 0; i < 16; i++) r[8*i+:8] = base + 8'(i);
      return r;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      expect_item(0, 8'h00, 32'h0, "R9 cmd");
      expect_item(0, 8'h04, 32'h0, "R9 arg");
      expect_item(0, 8'h24, 32'h0, "R9 cfg");
      expect_item(0, 8'h20, 32'h0, "R9 sts");
      expect_item(0, 8'h1C, 32'h0, "R9 rsp3");
      expect_item(1, 8'h00, 32'h0, "R9 irq");

      // R1 / R2 short response
      wr(8'h04, 32'hCAFEF00D);
      wr(8'h00, 32'h0000_8011);
      expect_item(2, 8'h00, 32'h51, "R1 req idx");
      expect_item(3, 8'h00, 32'hCAFEF00D, "R1 arg");
      expect_item(0, 8'h00, 32'h8011, "R1 pending bit");
      reply(4, {96'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA, 32'h7856_3412});
      expect_item(2, 8'h00, 32'h11, "R1 req dropped");
      expect_item(0, 8'h00, 32'h0011, "R1 go cleared");
      expect_item(0, 8'h10, 32'h12345678, "R2 word0");
      expect_item(0, 8'h14, 32'h0, "R2 word1");
      expect_item(0, 8'h1C, 32'h0, "R2 word3");
      expect_item(0, 8'h20, 32'h0, "R2 no status");

      // R3 long response
      wr(8'h00, 32'h0000_8202);
      expect_item(2, 8'h00, 32'h42, "R3 req");
      reply(16, ramp(8'h10));
      expect_item(0, 8'h10, 32'h1C1D1E1F, "R3 word0");
      expect_item(0, 8'h14, 32'h18191A1B, "R3 word1");
      expect_item(0, 8'h18, 32'h14151617, "R3 word2");
      expect_item(0, 8'h1C, 32'h10111213, "R3 word3");
      expect_item(0, 8'h00, 32'h0202, "R3 cmd");

      // R4 long command with 4 bytes
      wr(8'h00, 32'h0000_8203);
      reply(4, ramp(8'hD0));
      expect_item(0, 8'h00, 32'h4203, "R4 fail flag");
      expect_item(0, 8'h20, 32'h040, "R4 timeout bit");
      expect_item(0, 8'h10, 32'h1C1D1E1F, "R4 word0 kept");
      expect_item(0, 8'h1C, 32'h10111213, "R4 word3 kept");
      expect_item(1, 8'h00, 32'h0, "R8 timeout no irq");
      repeat (3) @(negedge clk);
      expect_item(0, 8'h00, 32'h4203, "R12 flag sticky");
      wr(8'h20, 32'h040);
      expect_item(0, 8'h20, 32'h0, "R7 clear timeout");

      // R4 zero length and odd length
      wr(8'h00, 32'h0000_8005);
      reply(0, '0);
      expect_item(0, 8'h00, 32'h4005, "R4 zero length");
      expect_item(0, 8'h20, 32'h040, "R4 zero length status");
      wr(8'h20, 32'hFFFF_FFFF);
      expect_item(0, 8'h20, 32'h0, "R7 clear all");
      wr(8'h00, 32'h0000_8006);
      reply(7, ramp(8'h00));
      expect_item(0, 8'h00, 32'h4006, "R4 odd length");
      wr(8'h20, 32'h7FF);
      wr(8'h00, 32'h0000_8007);
      reply(4, ramp(8'h01));
      expect_item(0, 8'h00, 32'h0007, "R12 cleared by rewrite");
      expect_item(0, 8'h10, 32'h01020304, "R2 second short");
      expect_item(0, 8'h14, 32'h0, "R2 word1 zeroed");

      // R5 no response expected
      wr(8'h00, 32'h0000_8408);
      reply(0, ramp(8'h55));
      expect_item(0, 8'h00, 32'h0408, "R5 no fail");
      expect_item(0, 8'h20, 32'h0, "R5 no status");
      expect_item(0, 8'h10, 32'h01020304, "R5 word0 kept");

      // R6 busy-wait
      wr(8'h00, 32'h0000_8C09);
      reply(0, '0);
      expect_item(0, 8'h20, 32'h0, "R6 disabled");
      expect_item(1, 8'h00, 32'h0, "R6 disabled irq");
      wr(8'h24, 32'h400);
      expect_item(0, 8'h24, 32'h400, "R6 cfg readback");
      wr(8'h00, 32'h0000_8C09);
      reply(0, '0);
      expect_item(0, 8'h20, 32'h400, "R6 enabled");
      expect_item(1, 8'h00, 32'h1, "R8 irq high");
      wr(8'h20, 32'h040);
      expect_item(0, 8'h20, 32'h400, "R7 other bit kept");
      expect_item(1, 8'h00, 32'h1, "R8 irq stays");
      wr(8'h20, 32'h400);
      expect_item(0, 8'h20, 32'h0, "R7 busy cleared");
      expect_item(1, 8'h00, 32'h0, "R8 irq low");

      // R10 ignored registers
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h0C, 32'h0000_07FF);
      wr(8'h44, 32'h1234_5678);
      expect_item(0, 8'h08, 32'h0, "R10 timeout reads 0");
      expect_item(0, 8'h0C, 32'h0, "R10 divider reads 0");
      expect_item(0, 8'h44, 32'h0, "R10 unmapped reads 0");
      expect_item(0, 8'h04, 32'hCAFEF00D, "R10 arg kept");
      expect_item(0, 8'h00, 32'h0C09, "R10 cmd kept");
      expect_item(0, 8'h24, 32'h400, "R10 cfg kept");
      expect_item(0, 8'h10, 32'h01020304, "R10 rsp kept");

      // R11 writes while outstanding
      wr(8'h04, 32'h77);
      wr(8'h00, 32'h0000_8021);
      wr(8'h00, 32'h0000_803F);
      wr(8'h04, 32'h99);
      expect_item(2, 8'h00, 32'h61, "R11 idx stable");
      expect_item(3, 8'h00, 32'h77, "R11 arg stable");
      reply(4, ramp(8'h40));
      expect_item(0, 8'h00, 32'h0021, "R11 cmd kept");
      expect_item(0, 8'h04, 32'h77, "R11 arg kept");
      expect_item(0, 8'h10, 32'h40414243, "R11 response");

      @(negedge clk);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule